// File: doc/BRIEF.md
# Direct Digital Synthesis Sine Generator

This block produces a stream of unsigned 12-bit codes for a DAC that trace a sine wave. Its frequency, amplitude and shape are set through a small write-only register port. The synthesis clock is intended to be 16 MHz. A 30-bit phase accumulator advances every clock by a 24-bit tuning word. The output frequency is therefore tuning_word × 16 MHz / 2^30, which gives steps of about 0.015 Hz. A tuning word of about 67,109 gives 1 kHz.

The ten most significant phase bits address a sine table that stores only one quarter of a period. The signed sample taken from the table is scaled by the amplitude register and shifted to mid-scale. It is then clamped to the DAC range. A global enable register holds several independent enable bits, and only one of them gates the generator. The whole register is brought out so that neighbouring analog-control logic can decode the other bits.

Register write map, selected by `wr_addr` on a cycle with `wr_en` high: 0 is the tuning word, 1 is the amplitude, 2 is the shape select, and 3 is the global enables.

Top module: `dds_sine_gen`

## Requirements
- R1: After reset, `dac_code` is 2048 and `gen_enables` is 0. All registers are zero, and the phase is zero.
- R2: A write to address 0 keeps only `wr_data[23:0]` as the tuning word. Bits 31:24 have no effect on the output.
- R3: While the generator runs, the phase (30 bits) adds the zero-extended tuning word on every clock and wraps modulo 2^30. The table address is phase[29:20].
- R4: For table address n (0..1023), the signed sample is sign × round(2047 × |sin(2π(n+0.5)/1024)|). The sign is negative exactly when n ≥ 512.
- R5: A write to address 1 keeps `wr_data[11:0]` as the amplitude A. The code is floor(sample × A / 2048) + 2048, clamped to the range 0..4095. A = 0 gives 2048.
- R6: The generator runs only while `gen_enables[4]` is 1 and the shape field is 1. When it is not running, the phase returns to zero and the output settles at 2048.
- R7: A write to address 2 keeps `wr_data[1:0]` as the shape field. Only value 1 selects the sine. The values 0, 2 and 3 behave as if the generator were disabled.
- R8: A write to address 3 keeps `wr_data[15:0]` and shows it on `gen_enables` from the next cycle. Bits other than bit 4 do not change the waveform.
- R9: A new tuning word is used from the next clock onwards without clearing the phase, so frequency changes keep the phase continuous.
- R10: The latency is fixed. Let k ≥ 1 count the rising edges since the run condition became true (k = 1 is the first edge at which it is true). After edge k+2, `dac_code` reflects the phase reached after edge k. An amplitude change is applied at the output stage on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synthesis clock (16 MHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 tuning word, 1 amplitude, 2 shape, 3 global enables |
| wr_data | input | 32 | Write data |
| dac_code | output | 12 | Unsigned DAC code, mid-scale 2048 |
| gen_enables | output | 16 | Global enable register contents |

## Verification
The bench drives the tuning word close to 2^24 so that the phase wraps every few dozen cycles and every quadrant of the mirrored table is reached. A design with a wrong mirror or sign would show a reflected or inverted lobe. Amplitudes of 0, 2048 and 4095 test the floor rounding and both clamps. A design that truncates toward zero, or that lets the sum wrap, gives codes off by one or folded around. Writes with garbage in the upper data bits would expose missing masks. A tuning-word change in the middle of a run, and toggles of the unrelated enable bits, would expose a phase reset where none belongs. Disabling, or choosing a non-sine shape, must bring the phase back to zero, so that a later restart begins again from the first sample.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W  = 30;
  localparam int FCW_W    = 24;
  localparam int AMP_W    = 12;
  localparam int DAC_W    = 12;
  localparam int LUT_AW   = 10;
  localparam int CFG_W    = 16;
  localparam int TYPE_W   = 2;
  localparam int RUN_BIT  = 4;
  localparam logic [TYPE_W-1:0] SHAPE_SINE = 2'd1;

  typedef enum logic [1:0] {
    SEL_TUNE  = 2'd0,
    SEL_AMP   = 2'd1,
    SEL_SHAPE = 2'd2,
    SEL_GLOB  = 2'd3
  } reg_sel_e;

  // Magnitude of one quarter-wave entry, sampled half a step off the grid
  function automatic int quarter_mag(int k, int full_len, int peak);
    real ang;
    ang = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / real'(full_len);
    return $rtoi(real'(peak) * $sin(ang) + 0.5);
  endfunction
endpackage

// File: rtl/dds_regs.sv
module dds_regs
  import dds_pkg::*;
#(
  parameter int TW_W  = FCW_W,
  parameter int A_W   = AMP_W,
  parameter int T_W   = TYPE_W,
  parameter int G_W   = CFG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [31:0]    wr_data,
  output logic [TW_W-1:0] tune_o,
  output logic [A_W-1:0]  amp_o,
  output logic [T_W-1:0]  shape_o,
  output logic [G_W-1:0]  glob_o
);
  logic tune_ce, amp_ce, shape_ce, glob_ce;

  always_comb begin
    tune_ce  = wr_en && (reg_sel_e'(wr_addr) == SEL_TUNE);
    amp_ce   = wr_en && (reg_sel_e'(wr_addr) == SEL_AMP);
    shape_ce = wr_en && (reg_sel_e'(wr_addr) == SEL_SHAPE);
    glob_ce  = wr_en && (reg_sel_e'(wr_addr) == SEL_GLOB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_o  <= '0;
      amp_o   <= '0;
      shape_o <= '0;
      glob_o  <= '0;
    end else begin
      if (tune_ce)  tune_o  <= wr_data[TW_W-1:0];
      if (amp_ce)   amp_o   <= wr_data[A_W-1:0];
      if (shape_ce) shape_o <= wr_data[T_W-1:0];
      if (glob_ce)  glob_o  <= wr_data[G_W-1:0];
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int P_W  = PHASE_W,
  parameter int TW_W = FCW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [TW_W-1:0] tune_i,
  output logic [P_W-1:0]  phase_o,
  output logic            live_o
);
  logic [P_W-1:0] phase_d;

  always_comb begin
    if (run_i) phase_d = phase_o + P_W'(tune_i);
    else       phase_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= '0;
      live_o  <= 1'b0;
    end else begin
      phase_o <= phase_d;
      live_o  <= run_i;
    end
  end

  // R6: a stopped generator returns its phase to zero
  a_r6_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (phase_o == '0));
  // R9: a zero tuning word freezes the phase without clearing it
  a_r9_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tune_i == '0) |=> $stable(phase_o));
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut
  import dds_pkg::*;
#(
  parameter int AW  = LUT_AW,
  parameter int S_W = DAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr_i,
  input  logic                  valid_i,
  output logic signed [S_W-1:0] sample_o,
  output logic                  valid_o
);
  localparam int QAW  = AW - 2;
  localparam int QLEN = 1 << QAW;
  localparam int PEAK = (1 << (S_W - 1)) - 1;

  logic [S_W-2:0] qtab [QLEN];

  for (genvar i = 0; i < QLEN; i++) begin : g_qtab
    localparam int MAG = quarter_mag(i, 1 << AW, PEAK);
    assign qtab[i] = (S_W-1)'(MAG);
  end

  logic [1:0]            quad;
  logic [QAW-1:0]        idx;
  logic [S_W-2:0]        mag;
  logic signed [S_W-1:0] sample_d;

  always_comb begin
    quad     = addr_i[AW-1:AW-2];
    idx      = quad[0] ? ~addr_i[QAW-1:0] : addr_i[QAW-1:0];
    mag      = qtab[idx];
    sample_d = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      sample_o <= sample_d;
      valid_o  <= valid_i;
    end
  end

  // R4: second half of the period yields negative samples only
  a_r4_half_sign: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sample_o[S_W-1] == $past(addr_i[AW-1])));
endmodule

// File: rtl/dds_shaper.sv
module dds_shaper
  import dds_pkg::*;
#(
  parameter int S_W = DAC_W,
  parameter int A_W = AMP_W,
  parameter int D_W = DAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [S_W-1:0] sample_i,
  input  logic                  valid_i,
  input  logic [A_W-1:0]        amp_i,
  output logic [D_W-1:0]        dac_o
);
  localparam int PROD_W = S_W + A_W + 1;
  localparam int MID    = 1 << (D_W - 1);
  localparam int TOP    = (1 << D_W) - 1;

  logic signed [PROD_W-1:0] prod, scaled, summed;
  logic [D_W-1:0]           dac_d;

  always_comb begin
    prod   = PROD_W'(sample_i) * $signed({1'b0, amp_i});
    scaled = prod >>> (D_W - 1);
    summed = scaled + PROD_W'(MID);
    if (!valid_i)                      dac_d = D_W'(MID);
    else if (summed < 0)               dac_d = '0;
    else if (summed > PROD_W'(TOP))    dac_d = D_W'(TOP);
    else                               dac_d = summed[D_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_o <= D_W'(MID);
    else        dac_o <= dac_d;
  end

  // R6: no valid sample means mid-scale at the output
  a_r6_idle_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> (dac_o == D_W'(MID)));
  // R5: zero amplitude flattens the wave onto mid-scale
  a_r5_zero_amp_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && amp_i == '0) |=> (dac_o == D_W'(MID)));
endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen
  import dds_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic [DAC_W-1:0]  dac_code,
  output logic [CFG_W-1:0]  gen_enables
);
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic [FCW_W-1:0]        tune;
  logic [AMP_W-1:0]        amp;
  logic [TYPE_W-1:0]       shape;
  logic                    run;
  logic [PHASE_W-1:0]      phase;
  logic                    live;
  logic signed [DAC_W-1:0] sample;
  logic                    sample_vld;

  dds_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tune_o(tune), .amp_o(amp), .shape_o(shape),
    .glob_o(gen_enables)
  );

  assign run = gen_enables[RUN_BIT] && (shape == SHAPE_SINE);

  dds_phase_acc u_acc (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .tune_i(tune),
    .phase_o(phase), .live_o(live)
  );

  dds_sine_lut u_lut (
    .clk(clk), .rst_n(rst_core_n), .addr_i(phase[PHASE_W-1:PHASE_W-LUT_AW]),
    .valid_i(live), .sample_o(sample), .valid_o(sample_vld)
  );

  dds_shaper u_shape (
    .clk(clk), .rst_n(rst_core_n), .sample_i(sample), .valid_i(sample_vld),
    .amp_i(amp), .dac_o(dac_code)
  );

  // R7: a non-sine shape never produces a live sample two stages later
  a_r7_shape_gates: assert property (@(posedge clk) disable iff (!rst_core_n)
    (shape != SHAPE_SINE) |=> !live);
endmodule

// File: tb/dds_sine_gen_test.sv
`timescale 1ns/1ps
module dds_sine_gen_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [11:0] dac_code;
  logic [15:0] gen_enables;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  // bench reference state
  logic [23:0] m_tune;
  logic [11:0] m_amp;
  logic [1:0]  m_shape;
  logic [15:0] m_glob;
  logic [29:0] m_phase;
  logic        m_live, m_vld;
  int          m_sample;
  int          m_dac;

  dds_sine_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dac_code(dac_code), .gen_enables(gen_enables)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int ref_sine(int n);
    real v;
    v = 2047.0 * $sin(2.0 * 3.14159265358979323846 * (real'(n) + 0.5) / 1024.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    return -$rtoi(-v + 0.5);
  endfunction

  function automatic int ref_code(int s, int a);
    int p, q, r;
    p = s * a;
    q = (p >= 0) ? p / 2048 : -((-p + 2047) / 2048);
    r = q + 2048;
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(bit we, logic [1:0] a, logic [31:0] d);
    bit run;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    cycles++;
    run = m_glob[4] && (m_shape == 2'd1);
    m_dac    = m_vld ? ref_code(m_sample, int'(m_amp)) : 2048;
    m_sample = ref_sine(int'(m_phase[29:20]));
    m_vld    = m_live;
    m_phase  = run ? m_phase + {6'd0, m_tune} : 30'd0;
    m_live   = run;
    if (we) begin
      case (a)
        2'd0: m_tune  = d[23:0];
        2'd1: m_amp   = d[11:0];
        2'd2: m_shape = d[1:0];
        default: m_glob = d[15:0];
      endcase
    end
    #1;
    check("dac_code", int'(dac_code), m_dac);
    check("gen_enables", int'(gen_enables), int'(m_glob));
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 2'd0, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired in %s actual %0d expected 0", tag, cycles);
    summary();
  end

  initial begin
    m_tune = '0; m_amp = '0; m_shape = '0; m_glob = '0;
    m_phase = '0; m_live = 0; m_vld = 0; m_sample = 0; m_dac = 2048;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    tag = "R1";  idle(5);
    check("R1 reset dac", int'(dac_code), 2048);

    tag = "R10"; // 1 kHz tone at full swing
    tick(1, 2'd0, 32'd67109);
    tick(1, 2'd1, 32'd2047);
    tick(1, 2'd2, 32'd1);
    tick(1, 2'd3, 32'h0010);
    idle(120);

    tag = "R2";  tick(1, 2'd0, 32'hAB00_4000); idle(80);
    tag = "R3";  tick(1, 2'd0, 32'h00FF_FFFF); idle(200);
    tag = "R4";  tick(1, 2'd0, 32'h0010_0000); idle(1100);
    tag = "R9";  tick(1, 2'd0, 32'h0012_3456); idle(60);
                 tick(1, 2'd0, 32'h0000_0000); idle(10);
                 tick(1, 2'd0, 32'h00FC_0001); idle(60);
    tag = "R5";  tick(1, 2'd1, 32'd0);          idle(40);
                 tick(1, 2'd1, 32'd4095);       idle(120);
                 tick(1, 2'd1, 32'hFFFF_F800);  idle(80);
    tag = "R8";  tick(1, 2'd3, 32'h0000_FFFF);  idle(30);
                 tick(1, 2'd3, 32'h1234_0010);  idle(30);
    tag = "R6";  tick(1, 2'd3, 32'h0000_FFEF);  idle(20);
                 tick(1, 2'd3, 32'h0000_0010);  idle(40);
    tag = "R7";  tick(1, 2'd2, 32'd2); idle(15);
                 tick(1, 2'd2, 32'd3); idle(15);
                 tick(1, 2'd2, 32'd0); idle(15);
                 tick(1, 2'd2, 32'hFFFF_FFFD); idle(40);

    void'($urandom(32'hD5D5_0001));
    for (int seg = 0; seg < 60; seg++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom_range(0, 3));
      d = $urandom();
      if (a == 2'd2 && $urandom_range(0, 3) != 0) d[1:0] = 2'd1;
      if (a == 2'd3) d[4] = ($urandom_range(0, 3) != 0);
      case (a)
        2'd0: tag = "R2";
        2'd1: tag = "R5";
        2'd2: tag = "R7";
        default: tag = "R8";
      endcase
      tick(1, a, d);
      idle(int'($urandom_range(20, 80)));
    end

    summary();
  end
endmodule